// File: doc/BRIEF.md
# Processor Interrupt Gating Unit

This block makes the final decision on whether a processor core accepts a hardware interrupt. It combines two conditions. The first is a set of state qualifiers: the global enable, the exception and error levels, the debug-mode flag and the per-thread exemption. Together these say whether the core may be interrupted at all. The second is the pending-line vector, judged against the mask field of the status register. The two fields sit at the same bit position in their registers, so a single field extraction upstream produces both operands.

A mode input selects how that vector comparison is made. With the mode low, each pending line is gated by its own mask bit. With the mode high, an external vectoring controller drives the pending field as a requested priority level. The mask field is then read as the current level, and a request is accepted only when it is strictly above that level. Both outputs are registered, so each reflects the inputs of the previous clock.

Top module: `irq_gate_top`

## Requirements
- R1: `irq_enabled` is 1 one clock after the inputs show `stat_ie`=1, `stat_exl`=0, `stat_erl`=0, `dbg_mode`=0 and an inactive thread exemption; under any other combination it is 0.
- R2: `dbg_mode`=1 forces `irq_enabled` and `irq_take` to 0 in the following cycle, whatever the other inputs are.
- R3: With parameter `MT_CAPABLE`=1 (the default), `thr_exempt`=1 disables interrupts. With `MT_CAPABLE`=0 the exemption cannot be set, so `thr_exempt` has no effect on either output.
- R4: With `vec_ext_mode`=0 (per-line mode), an interrupt is pending when `pend_lines & mask_lines` is non-zero.
- R5: With `vec_ext_mode`=1 (level mode), an interrupt is pending when `pend_lines`, read as an unsigned number, is strictly greater than `mask_lines`, read as an unsigned level. A pending value equal to the level is not pending.
- R6: A zero `pend_lines` never produces `irq_take`=1, in either mode.
- R7: `irq_take` is 1 in the cycle after the inputs make both the enable condition and the pending condition true. Otherwise it is 0.
- R8: While `rst`=1, each rising clock edge clears `irq_enabled` and `irq_take` to 0.
- R9: `irq_enabled` depends only on the qualifier inputs. `pend_lines`, `mask_lines` and `vec_ext_mode` have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_ie | input | 1 | Global interrupt enable from status |
| stat_exl | input | 1 | Exception-level bit from status |
| stat_erl | input | 1 | Error-level bit from status |
| dbg_mode | input | 1 | Core is in debug mode |
| thr_exempt | input | 1 | Current thread is exempt from interrupts |
| vec_ext_mode | input | 1 | 1: external vectoring controller (level mode); 0: per-line mode |
| pend_lines | input | LINE_W | Pending field of the cause register |
| mask_lines | input | LINE_W | Mask field of the status register |
| irq_enabled | output | 1 | Registered enable condition |
| irq_take | output | 1 | Registered decision to take an interrupt |

## Verification
The bench walks every combination of the five qualifier bits in both modes, with random 8-bit pending and mask values, and compares both outputs with a behavioural model on every clock.

In per-line mode the random values separate a real bitwise overlap from a design that merely tests for any non-zero pending value. In level mode they separate the unsigned magnitude comparison from the bitwise overlap.

Directed patterns then target the points a wrong comparison would miss:
- pending equal to the level, which must not be accepted;
- pending one step above the level, which must be accepted;
- pending at zero, which must never be accepted;
- pending and level both at the all-ones value, which must not be accepted.

A second instance built without multithread support shows that the exemption input is then ignored.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  parameter int unsigned LINE_W_DEF = 8;

  typedef enum logic {
    MODE_LINES = 1'b0,
    MODE_LEVEL = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/irq_enable_eval.sv
module irq_enable_eval #(
  parameter bit MT_CAPABLE = 1'b1
) (
  input  logic stat_ie,
  input  logic stat_exl,
  input  logic stat_erl,
  input  logic dbg_mode,
  input  logic thr_exempt,
  output logic en_ok
);
  logic exempt_eff;

  generate
    if (MT_CAPABLE) begin : g_mt
      assign exempt_eff = thr_exempt;
    end else begin : g_st
      logic unused_exempt;
      assign unused_exempt = thr_exempt;
      assign exempt_eff    = 1'b0;
    end
  endgenerate

  logic blocked;
  always_comb begin
    blocked = stat_exl | stat_erl | dbg_mode | exempt_eff;
    en_ok   = stat_ie & ~blocked;
  end
endmodule

// File: rtl/irq_pend_eval.sv
module irq_pend_eval
  import irq_gate_pkg::*;
#(
  parameter int unsigned LINE_W = LINE_W_DEF
) (
  input  logic              mode_bit,
  input  logic [LINE_W-1:0] pend_lines,
  input  logic [LINE_W-1:0] mask_lines,
  output logic              pend_ok
);
  logic [LINE_W-1:0] line_hit;
  logic              any_line;
  logic              above_level;
  irq_mode_e         mode;

  genvar gi;
  generate
    for (gi = 0; gi < LINE_W; gi++) begin : g_line
      assign line_hit[gi] = pend_lines[gi] & mask_lines[gi];
    end
  endgenerate

  always_comb begin
    mode        = irq_mode_e'(mode_bit);
    any_line    = |line_hit;
    above_level = (pend_lines > mask_lines);
    unique case (mode)
      MODE_LEVEL: pend_ok = above_level;
      default:    pend_ok = any_line;
    endcase
  end
endmodule

// File: rtl/irq_gate_top.sv
module irq_gate_top
  import irq_gate_pkg::*;
#(
  parameter int unsigned LINE_W     = LINE_W_DEF,
  parameter bit          MT_CAPABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_ie,
  input  logic              stat_exl,
  input  logic              stat_erl,
  input  logic              dbg_mode,
  input  logic              thr_exempt,
  input  logic              vec_ext_mode,
  input  logic [LINE_W-1:0] pend_lines,
  input  logic [LINE_W-1:0] mask_lines,
  output logic              irq_enabled,
  output logic              irq_take
);
  logic en_ok;
  logic pend_ok;

  irq_enable_eval #(.MT_CAPABLE(MT_CAPABLE)) u_enable (
    .stat_ie    (stat_ie),
    .stat_exl   (stat_exl),
    .stat_erl   (stat_erl),
    .dbg_mode   (dbg_mode),
    .thr_exempt (thr_exempt),
    .en_ok      (en_ok)
  );

  irq_pend_eval #(.LINE_W(LINE_W)) u_pend (
    .mode_bit   (vec_ext_mode),
    .pend_lines (pend_lines),
    .mask_lines (mask_lines),
    .pend_ok    (pend_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_enabled <= 1'b0;
      irq_take    <= 1'b0;
    end else begin
      irq_enabled <= en_ok;
      irq_take    <= en_ok & pend_ok;
    end
  end
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int unsigned LINE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              stat_exl,
  input logic              stat_erl,
  input logic              dbg_mode,
  input logic              vec_ext_mode,
  input logic [LINE_W-1:0] pend_lines,
  input logic [LINE_W-1:0] mask_lines,
  input logic              irq_enabled,
  input logic              irq_take
);
  // R7
  take_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> irq_enabled);

  // R1
  level_block_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(stat_exl) || $past(stat_erl)) |-> !irq_enabled);

  // R2
  debug_block_chk: assert property (@(posedge clk) disable iff (rst)
    $past(dbg_mode) |-> (!irq_enabled && !irq_take));

  // R6
  zero_pend_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pend_lines) == '0) |-> !irq_take);

  // R5
  equal_level_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(vec_ext_mode) && ($past(pend_lines) == $past(mask_lines))) |-> !irq_take);

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(vec_ext_mode) && (($past(pend_lines) & $past(mask_lines)) == '0)) |-> !irq_take);

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_enabled && !irq_take));
endmodule

bind irq_gate_top irq_gate_chk #(.LINE_W(LINE_W)) u_irq_gate_chk (
  .clk          (clk),
  .rst          (rst),
  .stat_exl     (stat_exl),
  .stat_erl     (stat_erl),
  .dbg_mode     (dbg_mode),
  .vec_ext_mode (vec_ext_mode),
  .pend_lines   (pend_lines),
  .mask_lines   (mask_lines),
  .irq_enabled  (irq_enabled),
  .irq_take     (irq_take)
);

// File: tb/test_irq_gate_top.sv
`timescale 1ns/1ps
module test_irq_gate_top;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stat_ie = 0, stat_exl = 0, stat_erl = 0, dbg_mode = 0, thr_exempt = 0, vec_ext_mode = 0;
  logic [LW-1:0] pend_lines = '0, mask_lines = '0;
  logic en_a, take_a, en_b, take_b;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_gate_top #(.LINE_W(LW), .MT_CAPABLE(1'b1)) i_irq_gate_top (
    .clk(clk), .rst(rst), .stat_ie(stat_ie), .stat_exl(stat_exl), .stat_erl(stat_erl),
    .dbg_mode(dbg_mode), .thr_exempt(thr_exempt), .vec_ext_mode(vec_ext_mode),
    .pend_lines(pend_lines), .mask_lines(mask_lines),
    .irq_enabled(en_a), .irq_take(take_a)
  );

  irq_gate_top #(.LINE_W(LW), .MT_CAPABLE(1'b0)) i_irq_gate_top_st (
    .clk(clk), .rst(rst), .stat_ie(stat_ie), .stat_exl(stat_exl), .stat_erl(stat_erl),
    .dbg_mode(dbg_mode), .thr_exempt(thr_exempt), .vec_ext_mode(vec_ext_mode),
    .pend_lines(pend_lines), .mask_lines(mask_lines),
    .irq_enabled(en_b), .irq_take(take_b)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b (ie=%0b exl=%0b erl=%0b dbg=%0b ex=%0b mode=%0b pend=%0h mask=%0h)",
               tag, act, exp, stat_ie, stat_exl, stat_erl, dbg_mode, thr_exempt,
               vec_ext_mode, pend_lines, mask_lines);
    end
  endtask

  // Behavioural reference: one registered step.
  task automatic step(input logic [4:0] q, input logic md, input logic [LW-1:0] p, input logic [LW-1:0] m);
    int pi, mi;
    bit pend_exp, en_exp_a, en_exp_b;
    @(negedge clk);
    {stat_ie, stat_exl, stat_erl, dbg_mode, thr_exempt} = q;
    vec_ext_mode = md;
    pend_lines   = p;
    mask_lines   = m;
    pi = int'(p);
    mi = int'(m);
    if (md) pend_exp = (pi > mi);
    else    pend_exp = ((pi & mi) != 0);
    en_exp_b = q[4] && !q[3] && !q[2] && !q[1];
    en_exp_a = en_exp_b && !q[0];
    @(posedge clk);
    #2;
    check_bit("R1/R2/R3/R9 enabled", en_a, en_exp_a);
    check_bit("R4/R5/R6/R7 take", take_a, en_exp_a && pend_exp);
    check_bit("R3 enabled no-MT", en_b, en_exp_b);
    check_bit("R3/R7 take no-MT", take_b, en_exp_b && pend_exp);
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset holds both outputs low even with enabling inputs
    @(negedge clk);
    stat_ie = 1;
    pend_lines = 8'hFF;
    mask_lines = 8'hFF;
    repeat (3) @(posedge clk);
    #2;
    check_bit("R8 reset enabled", en_a, 1'b0);
    check_bit("R8 reset take", take_a, 1'b0);
    @(negedge clk);
    rst = 0;

    // Sweep of both modes and all qualifier combinations
    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 32; s++) begin
        for (int k = 0; k < 6; k++) begin
          step(5'(s), 1'(md), LW'($urandom), LW'($urandom));
        end
      end
    end

    // R5: level mode boundaries
    step(5'b10000, 1'b1, 8'h40, 8'h40);
    step(5'b10000, 1'b1, 8'h41, 8'h40);
    step(5'b10000, 1'b1, 8'hFF, 8'hFF);
    step(5'b10000, 1'b1, 8'h01, 8'h00);
    step(5'b10000, 1'b1, 8'h03, 8'h80);

    // R6: zero pending in both modes
    step(5'b10000, 1'b1, 8'h00, 8'h00);
    step(5'b10000, 1'b0, 8'h00, 8'hFF);

    // R4: disjoint vs overlapping lines
    step(5'b10000, 1'b0, 8'hF0, 8'h0F);
    step(5'b10000, 1'b0, 8'h81, 8'h01);

    // R3: exemption ignored without MT support
    step(5'b10001, 1'b0, 8'h01, 8'h01);

    // R2: debug mode blocks everything
    step(5'b10010, 1'b0, 8'hFF, 8'hFF);

    // R8: reset asserted again mid-run
    @(negedge clk);
    rst = 1;
    {stat_ie, stat_exl, stat_erl, dbg_mode, thr_exempt} = 5'b10000;
    pend_lines = 8'h0F;
    mask_lines = 8'h0F;
    @(posedge clk);
    #2;
    check_bit("R8 mid-run reset enabled", en_a, 1'b0);
    check_bit("R8 mid-run reset take", take_a, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule